// File: doc/BRIEF.md
# Three-Wire Latched Configuration Receiver

This block takes configuration words from a host over three slow serial lines: a shift clock, a data line and a latch strobe. It runs on a fast system clock. All three lines pass through two-stage synchronisers, and their edges are found in the system clock domain. On each detected rising edge of the shift clock, one data bit is shifted into a 24-bit holding word, most significant bit first.

When the latch strobe rises, the receiver checks how many bits arrived since the previous strobe. If the count is exactly 24, the two bits that arrived last (word bits 1:0) choose one of four destination registers, and only that register takes the whole word. If the count is any other value, the word is dropped, no register changes, and an error flag goes high. The bit count returns to zero on every strobe, so each frame starts from a known state.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, all four destination registers read zero and `frame_err` is low.
- R2: The stored word equals the 24 bits in the order they were shifted, so the first bit shifted lands in bit 23 and the last in bit 0.
- R3: Word bits 1:0 select the destination register. Code k writes register k, which appears on `cfg_regs[k*24 +: 24]` for k = 0..3.
- R4: A single latch updates only the selected register. The other three keep their values.
- R5: Shifting bits without a rising edge on the latch strobe changes no register.
- R6: If the latch strobe rises after a bit count other than 24 (for example 23 or 25), no register changes and `frame_err` reads 1.
- R7: A later latch that follows exactly 24 bits clears `frame_err` to 0.
- R8: The bit count restarts at zero on each latch rise, so a correct frame that follows a malformed one is accepted.
- R9: The data line is sampled only at the rising edge of the shift clock. Changes on it while the shift clock stays high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_latch | input | 1 | Latch strobe; its rising edge commits the word |
| cfg_regs | output | 96 | Four 24-bit destination registers, register k at bits k*24+23 : k*24 |
| frame_err | output | 1 | High after a latch that followed a bit count other than 24 |

## Verification
Words cover all four select codes and are chosen so that each destination has a distinct pattern. Any mixed-up routing or any write that spills into another register therefore shows up in the register that should have kept its value. Frames of 23 and 25 bits tell a missing bit apart from an extra bit, and a correct frame sent straight after them shows whether the counter restarts and the flag clears. A frame whose data line toggles while the shift clock is high separates sampling at the edge from sampling at the level. A full frame shifted with no strobe checks that the strobe alone commits a word.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned CFG_WORD_BITS = 24;
  localparam int unsigned CFG_SEL_BITS  = 2;
  localparam int unsigned CFG_SYNC_LINES = 3;
  // line index in the synchroniser vector
  localparam int unsigned LINE_CLK   = 0;
  localparam int unsigned LINE_DATA  = 1;
  localparam int unsigned LINE_LATCH = 2;
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int unsigned LINES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic meta_q, stab_q, last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
        last_q <= stab_q;
      end
    end
    assign level[g] = stab_q;
    assign rise[g]  = stab_q & ~last_q;
  end
endmodule

// File: rtl/cfg_shift_collect.sv
module cfg_shift_collect #(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned CNT_MAX = WORD_W + 1,
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              frame_end,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              word_full
);
  logic [WORD_W-1:0] word_q, word_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              word_en;

  always_comb begin
    word_en  = bit_stb;
    word_nxt = {word_q[WORD_W-2:0], bit_in};
    cnt_nxt  = cnt_q;
    if (frame_end)
      cnt_nxt = '0;
    else if (bit_stb && (cnt_q != CNT_W'(CNT_MAX)))
      cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (word_en) word_q <= word_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign word      = word_q;
  assign bit_cnt   = cnt_q;
  assign word_full = (cnt_q == CNT_W'(WORD_W));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NREG = 1 << SEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [WORD_W-1:0]      word,
  output logic [NREG*WORD_W-1:0] regs
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [WORD_W-1:0] q;
    logic              en;
    assign en = commit && (word[SEL_W-1:0] == SEL_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= word;
    end
    assign regs[r*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned WORD_W = CFG_WORD_BITS,
  parameter int unsigned SEL_W  = CFG_SEL_BITS,
  localparam int unsigned NREG  = 1 << SEL_W,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_data,
  input  logic                   ser_latch,
  output logic [NREG*WORD_W-1:0] cfg_regs,
  output logic                   frame_err
);
  logic                      rst_meta_q, rst_sync_n;
  logic [CFG_SYNC_LINES-1:0] line_lvl, line_rise;
  logic [WORD_W-1:0]         word;
  logic [CNT_W-1:0]          bit_cnt;
  logic                      word_full, lat_rise, commit;
  logic                      err_q, err_nxt, err_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cfg_line_sync #(.LINES(CFG_SYNC_LINES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .async_in({ser_latch, ser_data, ser_clk}),
    .level(line_lvl), .rise(line_rise)
  );

  assign lat_rise = line_rise[LINE_LATCH];

  cfg_shift_collect #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n),
    .bit_in(line_lvl[LINE_DATA]), .bit_stb(line_rise[LINE_CLK]),
    .frame_end(lat_rise),
    .word(word), .bit_cnt(bit_cnt), .word_full(word_full)
  );

  assign commit = lat_rise & word_full;

  cfg_reg_bank #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .commit(commit), .word(word), .regs(cfg_regs)
  );

  always_comb begin
    err_en  = lat_rise;
    err_nxt = ~word_full;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  err_q <= 1'b0;
    else if (err_en)  err_q <= err_nxt;
  end

  assign frame_err = err_q;
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned CNT_W  = 5,
  localparam int unsigned NREG  = 1 << SEL_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NREG*WORD_W-1:0] regs,
  input logic                   err,
  input logic                   lat_rise,
  input logic [CNT_W-1:0]       cnt
);
  logic [NREG*WORD_W-1:0] prev_q;
  logic [NREG-1:0]        chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= regs;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_chg
    assign chg[r] = regs[r*WORD_W +: WORD_W] != prev_q[r*WORD_W +: WORD_W];
  end

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  assert_latch_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> $past(lat_rise));

  assert_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && cnt != CNT_W'(WORD_W)) |=> (!(|chg) && err));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && cnt == CNT_W'(WORD_W)) |=> !err);

  assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> (cnt == '0));
endmodule

bind serial_cfg_port serial_cfg_port_chk #(
  .WORD_W(WORD_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .regs(cfg_regs), .err(frame_err),
  .lat_rise(lat_rise), .cnt(bit_cnt)
);

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
  localparam int W = 24;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
  logic [N*W-1:0] cfg_regs;
  logic frame_err;
  int checks = 0, fails = 0;
  logic [W-1:0] exp_r [N];

  always #4 clk = ~clk;

  serial_cfg_port i_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .cfg_regs(cfg_regs), .frame_err(frame_err)
  );

  localparam logic [W-1:0] VEC [6] = '{
    24'h123450, 24'hABCDE1, 24'h5A5A5A, 24'hFFFFFF, 24'h000001, 24'hC0FFEE
  };

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    for (int k = 0; k < N; k++) chk(tag, cfg_regs[k*W +: W], exp_r[k]);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // shift n bits of v, highest index first; glitch toggles data while clock high
  task automatic shift_bits(logic [W:0] v, int n, bit glitch);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
      if (glitch) begin
        ser_data = ~v[i];
        wait_n(4);
      end
      ser_clk = 1'b0;
      wait_n(2);
      ser_data = ~ser_data;
      wait_n(2);
    end
  endtask

  task automatic pulse_latch();
    wait_n(4);
    ser_latch = 1'b1;
    wait_n(5);
    ser_latch = 1'b0;
    wait_n(8);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < N; k++) exp_r[k] = '0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R1 reset state
    chk_all("R1 reset regs");
    chk("R1 reset err", {23'b0, frame_err}, 24'h0);

    // R2 R3 R4 table walk
    foreach (VEC[v]) begin
      shift_bits({1'b0, VEC[v]}, W, 1'b0);
      pulse_latch();
      exp_r[VEC[v][1:0]] = VEC[v];
      chk_all("R2/R3/R4 table word");
      chk("R7 err low on good word", {23'b0, frame_err}, 24'h0);
    end

    // R5 full word, no strobe
    shift_bits({1'b0, 24'h777772}, W, 1'b0);
    wait_n(10);
    chk_all("R5 no latch no change");
    pulse_latch();
    exp_r[2] = 24'h777772;
    chk_all("R2 late latch commits");

    // R6 short frame
    shift_bits({1'b0, 24'h999990}, W - 1, 1'b0);
    pulse_latch();
    chk_all("R6 short frame discarded");
    chk("R6 short frame err", {23'b0, frame_err}, 24'h1);

    // R6 long frame
    shift_bits({1'b1, 24'h888883}, W + 1, 1'b0);
    pulse_latch();
    chk_all("R6 long frame discarded");
    chk("R6 long frame err", {23'b0, frame_err}, 24'h1);

    // R7 R8 good frame after bad one
    shift_bits({1'b0, 24'h3C3C31}, W, 1'b0);
    pulse_latch();
    exp_r[1] = 24'h3C3C31;
    chk_all("R8 recovery after bad frame");
    chk("R7 err cleared", {23'b0, frame_err}, 24'h0);

    // R9 data toggles while shift clock high
    shift_bits({1'b0, 24'hA0B0C3}, W, 1'b1);
    pulse_latch();
    exp_r[3] = 24'hA0B0C3;
    chk_all("R9 edge sampling");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule